// File: doc/BRIEF.md
# Buffered-Update PWM Channel with Selectable Polarity

This block drives one pulse-width modulated output from an up counter, a period setting and a duty setting. The counter advances on an external count-enable tick and wraps to zero at the end of each period. The output sits at a starting level chosen by a polarity input. When the counter reaches the active duty value, the output moves to the other level. With polarity 1 the duty count is the high time. With polarity 0 it is the low time.

Software writes duty and period through a small register port. While the channel runs, a write lands in a staging register and only reaches the live setting at a safe moment: a period wrap, a counter-clear strobe, or any cycle in which the channel is disabled. Each period therefore uses either the old settings or the new ones, never a mix. Reads always return the staged (last written) value.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After reset, the staged and live duty and period are 0 and the counter is 0, so both register reads return 0.
- R2: While enabled and not cleared, the counter holds when `tick_i` is 0 and otherwise steps by one. From `per_live − 1` (or from any value when the live period is 0 or 1) it returns to 0, and that return is the period end.
- R3: With `pol_i`=1 and live duty below live period, `pwm_o` is 1 while the counter is below the live duty and 0 from the match onward, until the period end.
- R4: With `pol_i`=0 and live duty below live period, `pwm_o` is 0 while the counter is below the live duty and 1 from the match onward.
- R5: A live duty greater than or equal to the live period keeps `pwm_o` at the starting level (equal to `pol_i`) for the whole period. A live duty of 0 below the period keeps it at the opposite level for the whole period.
- R6: While enabled, a duty write (`wr_sel_i`=0) changes only the staged value. The live duty takes it on the edge of the next period end, and `pwm_o` keeps following the old duty until then.
- R7: `cnt_clr_i` high while enabled makes the counter 0 after the next clock edge, even if `tick_i` is also high. The same edge copies the staged values to the live ones.
- R8: While `chan_en_i` is 0, the counter is held at 0, `pwm_o` equals `~pol_i`, and every write reaches the live setting on the same edge. After enabling, counting starts from 0.
- R9: `rd_data_o` returns the staged duty for `rd_sel_i`=0 and the staged period for `rd_sel_i`=1. Either way it is the value most recently written.
- R10: A period write (`wr_sel_i`=1) follows the same staging rules as a duty write, taking effect at the next period end, on a counter clear, or at once while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable tick |
| chan_en_i | input | 1 | Channel enable |
| pol_i | input | 1 | Starting level of each period |
| cnt_clr_i | input | 1 | Counter clear strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 duty, 1 period |
| wr_data_i | input | CW | Write data |
| rd_sel_i | input | 1 | Read target: 0 duty, 1 period |
| rd_data_o | output | CW | Staged value of the selected register |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the channel with the default counter width of 8. It programs short periods of 3 and 5 counts, so each run covers dozens of wraps and both polarities. Mid-period writes show the delay until the next wrap takes effect. The short periods also make it cheap to reach the boundary settings: a duty above the period, a duty of zero, a clear that coincides with a tick, and changes made while disabled.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  typedef enum logic {
    SEL_DUTY = 1'b0,
    SEL_PER  = 1'b1
  } pwm_reg_sel_e;

  localparam int unsigned NUM_REGS = 2;

  // True when the next tick from cnt must wrap to zero.
  function automatic logic wrap_due(input int unsigned cnt, input int unsigned per);
    return (cnt + 1) >= per;
  endfunction

  // Output level inside an enabled period.
  function automatic logic level_at(input int unsigned cnt, input int unsigned duty,
                                    input int unsigned per, input logic pol);
    if (duty >= per) return pol;
    return (cnt < duty) ? pol : ~pol;
  endfunction

endpackage

// File: rtl/pwm_stage_reg.sv
module pwm_stage_reg #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [CW-1:0] data_i,
  input  logic          load_i,
  output logic [CW-1:0] staged_o,
  output logic [CW-1:0] live_o
);

  logic [CW-1:0] staged_q;
  logic [CW-1:0] staged_d;
  logic [CW-1:0] live_q;

  assign staged_d = wr_i ? data_i : staged_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      live_q   <= '0;
    end else begin
      staged_q <= staged_d;
      if (load_i) live_q <= staged_d;
    end
  end

  assign staged_o = staged_q;
  assign live_o   = live_q;

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o,
  output logic          period_end_o
);
  import pwm_dbuf_pkg::*;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap         = wrap_due(32'(cnt_q), 32'(per_i));
  assign period_end_o = en_i && !clr_i && tick_i && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i || clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= wrap ? '0 : cnt_q + CW'(1);
    end
  end

  assign cnt_o = cnt_q;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && clr_i |=> cnt_q == '0); // R7

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cnt_q == '0); // R8

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !clr_i && tick_i && !period_end_o |=> cnt_q == $past(cnt_q) + CW'(1)); // R2

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !clr_i && !tick_i |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int unsigned CW = 8
) (
  input  logic          en_i,
  input  logic          pol_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] per_i,
  output logic          match_o,
  output logic          pwm_o
);
  import pwm_dbuf_pkg::*;

  assign match_o = en_i && (cnt_i == duty_i) && (duty_i < per_i);
  assign pwm_o   = en_i ? level_at(32'(cnt_i), 32'(duty_i), 32'(per_i), pol_i) : ~pol_i;

endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          chan_en_i,
  input  logic          pol_i,
  input  logic          cnt_clr_i,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          rd_sel_i,
  output logic [CW-1:0] rd_data_o,
  output logic          pwm_o
);
  import pwm_dbuf_pkg::*;

  logic [CW-1:0] staged [NUM_REGS];
  logic [CW-1:0] live   [NUM_REGS];
  logic [CW-1:0] cnt;
  logic          period_end;
  logic          load_live;
  logic          duty_match;

  // Live settings may change only at a period end, a clear, or while idle.
  assign load_live = !chan_en_i || cnt_clr_i || period_end;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (wr_sel_i == g[0]);
    pwm_stage_reg #(.CW(CW)) i_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (hit),
      .data_i   (wr_data_i),
      .load_i   (load_live),
      .staged_o (staged[g]),
      .live_o   (live[g])
    );
  end

  pwm_counter #(.CW(CW)) i_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (chan_en_i),
    .tick_i       (tick_i),
    .clr_i        (cnt_clr_i),
    .per_i        (live[SEL_PER]),
    .cnt_o        (cnt),
    .period_end_o (period_end)
  );

  pwm_wave #(.CW(CW)) i_wave (
    .en_i    (chan_en_i),
    .pol_i   (pol_i),
    .cnt_i   (cnt),
    .duty_i  (live[SEL_DUTY]),
    .per_i   (live[SEL_PER]),
    .match_o (duty_match),
    .pwm_o   (pwm_o)
  );

  assign rd_data_o = rd_sel_i ? staged[SEL_PER] : staged[SEL_DUTY];

  AST_LIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en_i && cnt != '0 |-> $stable(live[SEL_DUTY]) && $stable(live[SEL_PER])); // R6

  AST_DUTY_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !wr_sel_i |=> staged[SEL_DUTY] == $past(wr_data_i)); // R9

  AST_PER_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_sel_i |=> staged[SEL_PER] == $past(wr_data_i)); // R10

  AST_MATCH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    duty_match |-> pwm_o == ~pol_i); // R3

endmodule

// File: tb/test_pwm_dbuf_channel.sv
module test_pwm_dbuf_channel;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, en = 1'b0, pol = 1'b1, clr = 1'b0, we = 1'b0, wsel = 1'b0, rsel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwm;

  logic nxt_en = 1'b0, nxt_pol = 1'b1;

  int total = 0, bad = 0;

  // Reference state
  int m_cnt = 0, m_dbuf = 0, m_pbuf = 0, m_dlive = 0, m_plive = 0;

  bit    q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;

  pwm_dbuf_channel #(.CW(8)) i_pwm_dbuf_channel (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .chan_en_i(en), .pol_i(pol),
    .cnt_clr_i(clr), .wr_en_i(we), .wr_sel_i(wsel), .wr_data_i(wdata),
    .rd_sel_i(rsel), .rd_data_o(rdata), .pwm_o(pwm)
  );

  function automatic bit ref_level(int c, int d, int p, bit e, bit pl);
    int high_span;
    bit first_phase;
    if (!e) return !pl;
    high_span   = (d >= p) ? 1000 : d;
    first_phase = (c < high_span);
    return pl ? first_phase : !first_phase;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected output.
  task automatic step(input bit tk, input bit cl, input bit w, input bit s,
                      input int d, input string tag);
    int  bd, bp;
    bit  ld, endp;
    @(negedge clk);
    en = nxt_en; pol = nxt_pol; tick = tk; clr = cl; we = w; wsel = s; wdata = 8'(d);
    bd = (w && !s) ? d : m_dbuf;
    bp = (w && s) ? d : m_pbuf;
    endp = en && !cl && tk && (m_cnt + 1 >= m_plive);
    ld = !en || cl || endp;
    if (!en || cl) m_cnt = 0;
    else if (tk) m_cnt = (m_cnt + 1 >= m_plive) ? 0 : m_cnt + 1;
    m_dbuf = bd; m_pbuf = bp;
    if (ld) begin m_dlive = bd; m_plive = bp; end
    q_exp.push_back(ref_level(m_cnt, m_dlive, m_plive, en, pol));
    q_tag.push_back(tag);
    @(posedge clk);
    #1;
    tick = 1'b0; clr = 1'b0; we = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 0, tag);
  endtask

  task automatic read_chk(input bit s, input string tag);
    int e;
    rsel = s;
    #1;
    e = s ? m_pbuf : m_dbuf;
    total++;
    if (int'(rdata) != e) begin
      bad++;
      $display("FAIL %s read sel=%0d got=%0d exp=%0d", tag, s, rdata, e);
    end
  endtask

  // Monitor: compares each queued expectation after its clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        bit    e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        total++;
        if (pwm !== e) begin
          bad++;
          $display("FAIL %s pwm got=%0b exp=%0b", t, pwm, e);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    read_chk(1'b0, "R1");
    read_chk(1'b1, "R1");
    step(1'b0, 1'b0, 1'b0, 1'b0, 0, "R1");
    // Disabled: writes go straight through, counter held, output inverted polarity
    step(1'b0, 1'b0, 1'b1, 1'b1, 5, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b0, 2, "R8");
    read_chk(1'b1, "R9");
    read_chk(1'b0, "R9");
    run(3, "R8");
    nxt_en = 1'b1;
    run(12, "R3");
    for (int i = 0; i < 8; i++) step(i[0], 1'b0, 1'b0, 1'b0, 0, "R2");
    nxt_pol = 1'b0;
    run(10, "R4");
    // Mid-period duty change waits for the wrap
    run(2, "R6");
    step(1'b1, 1'b0, 1'b1, 1'b0, 4, "R6");
    read_chk(1'b0, "R9");
    run(10, "R6");
    // Period shrinks below duty
    run(1, "R10");
    step(1'b1, 1'b0, 1'b1, 1'b1, 3, "R10");
    read_chk(1'b1, "R9");
    run(8, "R5");
    nxt_pol = 1'b1;
    run(4, "R5");
    step(1'b1, 1'b0, 1'b1, 1'b0, 0, "R5");
    run(7, "R5");
    // Clear strobe beats tick and loads staged values
    step(1'b1, 1'b0, 1'b1, 1'b0, 2, "R7");
    run(1, "R7");
    step(1'b1, 1'b1, 1'b0, 1'b0, 0, "R7");
    run(5, "R7");
    step(1'b1, 1'b0, 1'b1, 1'b1, 5, "R10");
    step(1'b1, 1'b1, 1'b0, 1'b0, 0, "R10");
    run(7, "R10");
    // Disable, reprogram, re-enable from zero
    nxt_en = 1'b0;
    run(3, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1, "R8");
    nxt_en = 1'b1;
    run(8, "R8");
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule